// File: doc/BRIEF.md
# Byte-offset concatenate-and-extract aligner

This block is a byte-granular funnel shifter for a packed SIMD datapath. It places a source operand under a destination operand to form one value of twice the operand width. It then returns the operand-width window that starts at a byte offset given by an 8-bit immediate. Bytes that would come from beyond the top of that double-width composite are filled with zero. The block therefore has defined results for every immediate value.

One control bit selects an operand width of 128 or 64 bits. The result is registered, so it appears one clock after the request strobe. Between requests the result register keeps its last value. Decode, memory operands and fault handling belong to the surrounding pipeline.

Top module: `byte_window_aligner`

## Requirements
- R1: The composite is formed with `lo_op` in its low half and `hi_op` in its high half. Composite byte 0 is bits [7:0] of `lo_op`, and its width is twice the selected operand width.
- R2: Result byte i equals composite byte (`shift_imm` + i). The offset counts whole bytes, not bits.
- R3: A `shift_imm` of zero returns the source operand `lo_op` unchanged. In 64-bit mode only its low 64 bits appear.
- R4: In 64-bit mode only bits [63:0] of each operand are used. Bits [127:64] of the result are zero.
- R5: A composite byte position at or above 32 (128-bit mode) or 16 (64-bit mode) reads as zero. An offset at or above that limit therefore yields an all-zero result.
- R6: `out_valid` equals `in_valid` delayed by one clock. `out_data` is loaded at the rising edge where `in_valid` is high.
- R7: While `in_valid` is low, `out_data` holds its previous value regardless of the other inputs.
- R8: While `rst_n` is low (asynchronous, active low), `out_valid` and `out_data` are zero.
- R9: `wide_mode` = 1 selects 128-bit operands, and `wide_mode` = 0 selects 64-bit operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| wide_mode | input | 1 | 1: 128-bit operands, 0: 64-bit operands |
| hi_op | input | 128 | Destination operand, upper half of the composite |
| lo_op | input | 128 | Source operand, lower half of the composite |
| shift_imm | input | 8 | Byte offset of the extracted window |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_data | output | 128 | Extracted window |

## Verification
The only state in this block is the result register and its valid flag. A wrong window, half order or fill shows on `out_data` on the first clock after the offending request. A stale or spuriously updated register shows on the first idle cycle where the bench changes the inputs without asserting the strobe. Offsets are swept across both composite limits in both widths. Junk is placed in the upper operand bits in 64-bit mode, so that a leak into the narrow result appears immediately.

// File: rtl/byte_window_aligner.sv
module byte_window_aligner #(
  parameter int OPW = 128,
  parameter int IMMW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            wide_mode,
  input  logic [OPW-1:0]  hi_op,
  input  logic [OPW-1:0]  lo_op,
  input  logic [IMMW-1:0] shift_imm,
  output logic            out_valid,
  output logic [OPW-1:0]  out_data
);
  localparam int HW  = OPW / 2;
  localparam int SHW = IMMW + 3;

  logic [2*OPW-1:0] comp_w;
  logic [OPW-1:0]   comp_n;
  logic [SHW-1:0]   sh_amt;
  logic [OPW-1:0]   win_w;
  logic [HW-1:0]    win_n;
  logic [OPW-1:0]   win;

  assign comp_w = {hi_op, lo_op};
  assign comp_n = {hi_op[HW-1:0], lo_op[HW-1:0]};
  assign sh_amt = {shift_imm, 3'b000};
  assign win_w  = OPW'(comp_w >> sh_amt);
  assign win_n  = HW'(comp_n >> sh_amt);
  assign win    = wide_mode ? win_w : {{HW{1'b0}}, win_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= win;
    end
  end
endmodule

// File: rtl/byte_window_aligner_chk.sv
module byte_window_aligner_chk #(
  parameter int OPW = 128,
  parameter int IMMW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            wide_mode,
  input logic [OPW-1:0]  lo_op,
  input logic [IMMW-1:0] shift_imm,
  input logic            out_valid,
  input logic [OPW-1:0]  out_data
);
  localparam int HW = OPW / 2;
  localparam int NB = OPW / 8;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R6
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R7
  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_mode) |=> (out_data[OPW-1:HW] == '0)); // R4
  AST_WIDE_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide_mode && shift_imm == '0) |=> (out_data == $past(lo_op))); // R3
  AST_NARROW_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_mode && shift_imm == '0) |=> (out_data[HW-1:0] == $past(lo_op[HW-1:0]))); // R3
  AST_WIDE_FAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide_mode && 32'(shift_imm) >= 2*NB) |=> (out_data == '0)); // R5
  AST_NARROW_FAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_mode && 32'(shift_imm) >= NB) |=> (out_data == '0)); // R5
endmodule

bind byte_window_aligner byte_window_aligner_chk #(.OPW(OPW), .IMMW(IMMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_mode(wide_mode),
  .lo_op(lo_op), .shift_imm(shift_imm), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/test_byte_window_aligner.sv
`timescale 1ns/1ps
module test_byte_window_aligner;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         wide_mode = 1'b1;
  logic [127:0] hi_op = '0;
  logic [127:0] lo_op = '0;
  logic [7:0]   shift_imm = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int applied = 0;
  int bad = 0;
  string cur_tag = "R8";
  string m_tag = "R8";
  logic         m_valid = 1'b0;
  logic [127:0] m_data = '0;

  always #5 clk = ~clk;

  byte_window_aligner i_byte_window_aligner (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_mode(wide_mode),
    .hi_op(hi_op), .lo_op(lo_op), .shift_imm(shift_imm),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [127:0] ref_window(logic w, logic [127:0] h, logic [127:0] l, logic [7:0] k);
    logic [7:0] cb [$];
    logic [127:0] r = '0;
    int nb = w ? 16 : 8;
    for (int i = 0; i < nb; i++) cb.push_back(l[8*i +: 8]);
    for (int i = 0; i < nb; i++) cb.push_back(h[8*i +: 8]);
    for (int i = 0; i < nb; i++) begin
      int p = int'(k) + i;
      if (p < cb.size()) r[8*i +: 8] = cb[p];
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= in_valid;
      m_tag   <= cur_tag;
      if (in_valid) m_data <= ref_window(wide_mode, hi_op, lo_op, shift_imm);
    end
  end

  always @(negedge clk) begin
    applied++;
    if (out_valid !== m_valid || out_data !== m_data) begin
      bad++;
      $display("FAIL %s: actual valid=%b data=%h expected valid=%b data=%h",
               m_tag, out_valid, out_data, m_valid, m_data);
    end
  end

  task automatic drive(logic v, logic w, logic [127:0] h, logic [127:0] l, logic [7:0] k, string tag);
    @(negedge clk);
    #1;
    in_valid = v; wide_mode = w; hi_op = h; lo_op = l; shift_imm = k; cur_tag = tag;
  endtask

  localparam logic [127:0] LO_PAT = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [127:0] HI_PAT = 128'h1f1e1d1c1b1a19181716151413121110;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(1, 1, HI_PAT, LO_PAT, 8'd0,   "R3 R9");
    drive(1, 1, HI_PAT, LO_PAT, 8'd5,   "R2");
    drive(1, 1, HI_PAT, LO_PAT, 8'd16,  "R1");
    drive(1, 1, HI_PAT, LO_PAT, 8'd31,  "R5");
    drive(1, 1, HI_PAT, LO_PAT, 8'd32,  "R5");
    drive(1, 1, HI_PAT, LO_PAT, 8'd200, "R5");
    drive(1, 1, HI_PAT, LO_PAT, 8'd255, "R5");
    drive(1, 0, {64'hdeadbeefcafef00d, HI_PAT[63:0]}, {64'h0123456789abcdef, LO_PAT[63:0]}, 8'd0, "R3 R4 R9");
    drive(1, 0, {64'hdeadbeefcafef00d, HI_PAT[63:0]}, {64'h0123456789abcdef, LO_PAT[63:0]}, 8'd3, "R4");
    drive(1, 0, {64'hdeadbeefcafef00d, HI_PAT[63:0]}, {64'h0123456789abcdef, LO_PAT[63:0]}, 8'd8, "R1");
    drive(1, 0, {64'hdeadbeefcafef00d, HI_PAT[63:0]}, {64'h0123456789abcdef, LO_PAT[63:0]}, 8'd15, "R5");
    drive(1, 0, {64'hdeadbeefcafef00d, HI_PAT[63:0]}, {64'h0123456789abcdef, LO_PAT[63:0]}, 8'd16, "R5");
    drive(1, 1, HI_PAT, LO_PAT, 8'd9, "R6");
    for (int n = 0; n < 4; n++)
      drive(0, n[0], {4{$urandom}}, {4{$urandom}}, 8'($urandom), "R7");
    for (int n = 0; n < 60; n++)
      drive(1'($urandom), 1'($urandom), {4{$urandom}}, {4{$urandom}}, 8'($urandom % 40), "R2 R6");
    drive(0, 1, '0, '0, 8'd0, "R7");
    @(negedge clk);
    #1 rst_n = 1'b0;
    cur_tag = "R8";
    @(negedge clk);
    if (out_valid !== 1'b0 || out_data !== '0) begin
      bad++;
      $display("FAIL R8: actual valid=%b data=%h expected valid=0 data=0", out_valid, out_data);
    end
    applied++;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL R6: watchdog expired, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule